// File: doc/BRIEF.md
# I2C EEPROM Write Target

This block is an I2C target that behaves like the write half of a serial EEPROM. It watches an open-drain SCL/SDA pair, sampled into the system clock. It accepts a write-mode device address, then a two-byte memory address sent high byte first, then any number of data bytes. It acknowledges each accepted byte by pulling SDA low.

Data bytes are not written to the array as they arrive. They go into a 32-byte page buffer, at a pointer whose five low bits advance and wrap inside the page. When a STOP ends a transaction that delivered at least one data byte, the buffered bytes are copied into an on-chip byte array during a programming window of fixed length. Throughout that window the target stays silent on the bus, so a host polls for completion by repeating the device address until it is acknowledged.

A write-protect input makes the lowest quarter of the array read-only. An array read port lets neighbouring on-chip logic see the stored bytes.

Top module: `eeprom_wr_target`

## Requirements
- R1: A device-address byte equal to {DEV_ADDR, 0} (default 0xA0) is acknowledged when not busy. Any other value, including the read form 0xA1, is not acknowledged, and the rest of that transaction is ignored.
- R2: After an accepted device address, the next two bytes form the memory address, high byte first. Both are acknowledged, as is every data byte that follows. SDA is only ever pulled or released while SCL is low.
- R3: Data byte k of a transaction is stored at the page base (address bits 11..5) combined with (start offset + k) mod 32. Address bits 11..5 never change within a transaction.
- R4: When more than 32 data bytes arrive, a later byte that lands on an already-filled page slot replaces the earlier one. Only the last value for each slot is committed.
- R5: The array does not change before STOP. A STOP after at least one data byte raises busy on the clock after the STOP is detected. Busy stays high for exactly WRITE_CYCLES clocks, and the buffered bytes are in the array once busy falls.
- R6: While busy is high, the device address is not acknowledged. Once busy has fallen, the same address is acknowledged again (completion polling).
- R7: With wp high at STOP, locations whose address bits 11..10 are 00 (0x000..0x3FF) are not modified, yet all bytes aimed at them are still acknowledged. Locations from 0x400 upward are written normally. With wp low, every location is writable.
- R8: Bits 15..12 of the high address byte are ignored. The array is addressed by bits 11..0 only.
- R9: A STOP before both address bytes are complete, or a STOP right after the address with no data byte, starts no write cycle: busy stays low.
- R10: While rst_n is low, sda_oe is 0 and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wp | input | 1 | Write-protect for the lowest quarter of the array |
| busy | output | 1 | High during the programming window |
| mem_raddr | input | ADDR_W (12) | Array read address |
| mem_rdata | output | 8 | Array byte at mem_raddr (combinational) |

## Verification
The assertions take for granted that the host changes SDA only while SCL is low, except at START and STOP. They also assume that each SCL phase lasts longer than the three-flop sampling delay, so that the target's acknowledge drive always begins and ends inside an SCL low phase.

The bench holds every SCL quarter-phase for ten system clocks and raises SDA before SCL when it sets up a repeated START. This keeps the SDA and SCL edges apart and never creates an unintended STOP. The programming window is long enough that a poll issued right after STOP still lands inside it.

// File: rtl/eeprom_wr_pkg.sv
// Package: shared types for the EEPROM write target.
package eeprom_wr_pkg;

    // Byte-level position within a write transaction.
    typedef enum logic [2:0] {
        LNK_IDLE,   // not addressed; waits for START
        LNK_DEV,    // receiving device address
        LNK_AHI,    // receiving address bits 15..8
        LNK_ALO,    // receiving address bits 7..0
        LNK_DATA    // receiving data bytes
    } link_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clk domain through two flops each. A third
// flop gives the previous level for edge detection. Flags SCL edges and the
// START/STOP conditions (SDA edge while SCL stays high).
// Assumes both lines are stable for several clk periods around each change.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_ff;
    logic [2:0] sda_ff;

    // Shift the raw lines through the synchronizer chains; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= 3'b111;
            sda_ff <= 3'b111;
        end else begin
            scl_ff <= {scl_ff[1:0], scl_in};
            sda_ff <= {sda_ff[1:0], sda_in};
        end
    end

    // Decode levels, edges and bus conditions from current and previous samples.
    always_comb begin
        scl_lvl   = scl_ff[1];
        sda_lvl   = sda_ff[1];
        scl_rise  = scl_ff[1] & ~scl_ff[2];
        scl_fall  = ~scl_ff[1] & scl_ff[2];
        start_det = scl_ff[1] & scl_ff[2] & sda_ff[2] & ~sda_ff[1];
        stop_det  = scl_ff[1] & scl_ff[2] & ~sda_ff[2] & sda_ff[1];
    end
endmodule

// File: rtl/ee_page_store.sv
// Module: ee_page_store
// Page buffer plus byte array. Received bytes land in the buffer with a
// per-slot valid flag. A commit opens a WRITE_CYCLES-long busy window.
// During its first PAGE_BYTES clocks, one slot per clock is copied to the
// array unless the slot is empty or write-protected.
// Assumes WRITE_CYCLES >= PAGE_BYTES, and that no buffer writes arrive while busy.
module ee_page_store #(
    parameter int ADDR_W       = 12,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 1000,
    localparam int PAGE_W      = $clog2(PAGE_BYTES),
    localparam int BASE_W      = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_clr,
    input  logic              buf_we,
    input  logic [PAGE_W-1:0] buf_idx,
    input  logic [7:0]        buf_wdata,
    input  logic [BASE_W-1:0] page_base,
    input  logic              commit,
    input  logic              wp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CYC_W = $clog2(WRITE_CYCLES + 1);

    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvld;
    logic [7:0]            mem  [DEPTH];
    logic [CYC_W-1:0]      cyc;
    logic [BASE_W-1:0]     base_lat;
    logic                  wp_lat;
    logic [PAGE_W-1:0]     slot;
    logic [ADDR_W-1:0]     tgt;
    logic                  tgt_prot;
    logic                  copy_en;

    // Track which page slots hold a byte for the pending commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      pvld <= '0;
        else if (buf_clr) pvld <= '0;
        else if (buf_we)  pvld[buf_idx] <= 1'b1;
    end

    // Store received bytes; a repeated slot simply overwrites.
    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_wdata;
    end

    // Programming window: latch page and protect state, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cyc      <= '0;
            wp_lat   <= 1'b0;
            base_lat <= '0;
        end else if (commit && !busy) begin
            busy     <= 1'b1;
            cyc      <= '0;
            wp_lat   <= wp;
            base_lat <= page_base;
        end else if (busy) begin
            if (cyc == CYC_W'(WRITE_CYCLES - 1)) busy <= 1'b0;
            cyc <= cyc + 1'b1;
        end
    end

    // Decide whether the slot visited this clock goes to the array.
    always_comb begin
        slot     = cyc[PAGE_W-1:0];
        tgt      = {base_lat, slot};
        tgt_prot = wp_lat && (tgt[ADDR_W-1 -: 2] == 2'b00);
        copy_en  = busy && (cyc < CYC_W'(PAGE_BYTES)) && pvld[slot] && !tgt_prot;
    end

    // Copy one buffered byte per clock into the array.
    always_ff @(posedge clk) begin
        if (copy_en) mem[tgt] <= pbuf[slot];
    end

    // Combinational array read port.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_wr_target.sv
// Module: eeprom_wr_target (top)
// I2C write-only EEPROM target. Sequences device address, two address
// bytes and data bytes, acknowledging each by driving sda_oe while SCL is
// low. Data goes to a page buffer; a STOP after data commits it.
// Assumes ADDR_W <= 16 and a host that changes SDA only while SCL is low,
// except for START and STOP.
module eeprom_wr_target
    import eeprom_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR     = 7'h50,
    parameter int          ADDR_W       = 12,
    parameter int          PAGE_BYTES   = 32,
    parameter int          WRITE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              wp,
    output logic              busy,
    input  logic [ADDR_W-1:0] mem_raddr,
    output logic [7:0]        mem_rdata
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    link_state_t       state;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic              in_ack;
    logic [7:0]        addr_hi;
    logic [PAGE_W-1:0] ptr;
    logic [BASE_W-1:0] base_q;
    logic              got_data;
    logic [15:0]       addr_full;
    logic              byte_done, accept;
    logic              buf_clr, buf_we, commit;

    i2c_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // Byte-completion and accept decisions for the current link state.
    always_comb begin
        addr_full = {addr_hi, shreg};
        byte_done = scl_fall && !in_ack && (bit_cnt == 4'd8);
        unique case (state)
            LNK_DEV:                   accept = (shreg == {DEV_ADDR, 1'b0}) && !busy;
            LNK_AHI, LNK_ALO, LNK_DATA: accept = 1'b1;
            default:                   accept = 1'b0;
        endcase
        buf_clr = byte_done && (state == LNK_DEV) && accept;
        buf_we  = byte_done && (state == LNK_DATA);
        commit  = stop_det && (state == LNK_DATA) && got_data;
    end

    // Link sequencer: bit shifting, acknowledge drive and state progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LNK_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            in_ack   <= 1'b0;
            sda_oe   <= 1'b0;
            addr_hi  <= '0;
            ptr      <= '0;
            base_q   <= '0;
            got_data <= 1'b0;
        end else if (start_det) begin
            state    <= LNK_DEV;
            bit_cnt  <= '0;
            in_ack   <= 1'b0;
            sda_oe   <= 1'b0;
            got_data <= 1'b0;
        end else if (stop_det) begin
            state   <= LNK_IDLE;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (state != LNK_IDLE) begin
            if (scl_rise && !in_ack && (bit_cnt < 4'd8)) begin
                shreg   <= {shreg[6:0], sda_lvl};
                bit_cnt <= bit_cnt + 4'd1;
            end
            if (byte_done) begin
                if (accept) begin
                    sda_oe <= 1'b1;
                    in_ack <= 1'b1;
                    unique case (state)
                        LNK_AHI: addr_hi <= shreg;
                        LNK_ALO: begin
                            base_q <= addr_full[ADDR_W-1:PAGE_W];
                            ptr    <= addr_full[PAGE_W-1:0];
                        end
                        LNK_DATA: begin
                            ptr      <= ptr + 1'b1;
                            got_data <= 1'b1;
                        end
                        default: ;
                    endcase
                end else begin
                    state <= LNK_IDLE;
                end
            end
            if (scl_fall && in_ack) begin
                sda_oe  <= 1'b0;
                in_ack  <= 1'b0;
                bit_cnt <= '0;
                unique case (state)
                    LNK_DEV: state <= LNK_AHI;
                    LNK_AHI: state <= LNK_ALO;
                    default: state <= LNK_DATA;
                endcase
            end
        end
    end

    ee_page_store #(
        .ADDR_W       (ADDR_W),
        .PAGE_BYTES   (PAGE_BYTES),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_clr   (buf_clr),
        .buf_we    (buf_we),
        .buf_idx   (ptr),
        .buf_wdata (shreg),
        .page_base (base_q),
        .commit    (commit),
        .wp        (wp),
        .rd_addr   (mem_raddr),
        .rd_data   (mem_rdata),
        .busy      (busy)
    );
endmodule

// File: rtl/eeprom_wr_target_chk.sv
// Module: eeprom_wr_target_chk
// Protocol and timing checks for eeprom_wr_target, bound into every instance.
// Assumes the host keeps each SCL phase longer than the sampling delay.
module eeprom_wr_target_chk #(
    parameter int WRITE_CYCLES = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_lvl,
    input logic sda_oe,
    input logic busy,
    input logic stop_det
);
    logic [31:0] run_len;

    // Measure how many clocks the current busy window has lasted.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 32'd1;
        else           run_len <= '0;
    end

    // R10: reset holds the bus released and the window closed.
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !busy));

    // R2: the acknowledge drive only changes while SCL is low.
    assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    // R6: no acknowledge begins during the programming window.
    assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !$rose(sda_oe));

    // R5: a programming window opens only right after a STOP.
    assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R5: the window lasts exactly WRITE_CYCLES clocks.
    assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 32'(WRITE_CYCLES)));
endmodule

bind eeprom_wr_target eeprom_wr_target_chk #(
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .stop_det (stop_det)
);

// File: tb/tb_eeprom_wr_target.sv
// Directed bench for eeprom_wr_target: one task per scenario.
module tb_eeprom_wr_target;
    localparam int Q  = 10;   // clocks per SCL quarter phase
    localparam int WC = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic        wp = 1'b0;
    logic        busy;
    logic [11:0] mem_raddr = '0;
    logic [7:0]  mem_rdata;
    logic [7:0]  tx_buf [64];
    int          n_tests = 0;
    int          n_fail  = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz
    assign sda_line = sda_m & ~sda_oe;

    eeprom_wr_target #(.WRITE_CYCLES(WC)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .wp(wp), .busy(busy),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quarter();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        sda_m = 1'b0; quarter();
        scl_m = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; quarter();
        scl_m = 1'b1; quarter();
        sda_m = 1'b1; quarter();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; quarter();
            scl_m = 1'b1; quarter(); quarter();
            scl_m = 1'b0; quarter();
        end
        sda_m = 1'b1; quarter();
        scl_m = 1'b1; quarter();
        ack = (sda_line == 1'b0);
        quarter();
        scl_m = 1'b0; quarter();
    endtask

    // Full write header plus n bytes from tx_buf; returns AND of all acks.
    task automatic do_write(input logic [15:0] a, input int n, input bit stop, output logic all_ack);
        logic ak;
        bus_start();
        send_byte(8'hA0, ak);    all_ack = ak;
        send_byte(a[15:8], ak);  all_ack &= ak;
        send_byte(a[7:0], ak);   all_ack &= ak;
        for (int i = 0; i < n; i++) begin
            send_byte(tx_buf[i], ak); all_ack &= ak;
        end
        if (stop) bus_stop();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    task automatic peek(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        mem_raddr = a;
        #1 d = mem_rdata;
    endtask

    task automatic single(input logic [15:0] a, input logic [7:0] d);
        logic ak;
        tx_buf[0] = d;
        do_write(a, 1, 1'b1, ak);
        wait_idle();
    endtask

    task automatic t_reset();
        check("R10 sda_oe in reset", {31'b0, sda_oe}, 32'h0);
        check("R10 busy in reset", {31'b0, busy}, 32'h0);
    endtask

    task automatic t_byte_write();
        logic ak; logic [7:0] d;
        single(16'h0812, 8'h11);
        tx_buf[0] = 8'h77;
        do_write(16'h0812, 1, 1'b0, ak);
        check("R1 R2 header and data acked", {31'b0, ak}, 32'h1);
        peek(12'h812, d);
        check("R5 array unchanged before STOP", {24'b0, d}, 32'h11);
        bus_stop();
        check("R5 busy after STOP", {31'b0, busy}, 32'h1);
        wait_idle();
        check("R5 busy ends", {31'b0, busy}, 32'h0);
        peek(12'h812, d);
        check("R5 byte committed", {24'b0, d}, 32'h77);
    endtask

    task automatic t_page_wrap();
        logic ak; logic [7:0] d;
        single(16'h0520, 8'h3C);
        for (int k = 0; k < 34; k++) tx_buf[k] = 8'(8'h40 + k);
        do_write(16'h051E, 34, 1'b1, ak);
        check("R2 all page bytes acked", {31'b0, ak}, 32'h1);
        wait_idle();
        peek(12'h51E, d); check("R4 slot 30 overwritten", {24'b0, d}, 32'h60);
        peek(12'h51F, d); check("R4 slot 31 overwritten", {24'b0, d}, 32'h61);
        peek(12'h500, d); check("R3 wrap to slot 0", {24'b0, d}, 32'h42);
        peek(12'h51D, d); check("R3 slot 29", {24'b0, d}, 32'h5F);
        peek(12'h520, d); check("R3 next page untouched", {24'b0, d}, 32'h3C);
    endtask

    task automatic t_polling();
        logic ak; logic [7:0] d;
        tx_buf[0] = 8'hC3;
        do_write(16'h0100, 1, 1'b1, ak);
        bus_start(); send_byte(8'hA0, ak); bus_stop();
        check("R6 no ack while busy", {31'b0, ak}, 32'h0);
        wait_idle();
        bus_start(); send_byte(8'hA0, ak);
        check("R6 ack after window", {31'b0, ak}, 32'h1);
        bus_stop();
        repeat (20) @(negedge clk);
        check("R9 poll stop starts no cycle", {31'b0, busy}, 32'h0);
        peek(12'h100, d); check("R6 polled write landed", {24'b0, d}, 32'hC3);
    endtask

    task automatic t_protect();
        logic ak; logic [7:0] d;
        wp = 1'b0;
        single(16'h03FF, 8'h12);
        peek(12'h3FF, d); check("R7 low quarter writable wp=0", {24'b0, d}, 32'h12);
        wp = 1'b1;
        tx_buf[0] = 8'hEE; tx_buf[1] = 8'hEF;
        do_write(16'h03FF, 2, 1'b1, ak);
        check("R7 protected bytes still acked", {31'b0, ak}, 32'h1);
        wait_idle();
        peek(12'h3FF, d); check("R7 protected location kept", {24'b0, d}, 32'h12);
        single(16'h0400, 8'h56);
        peek(12'h400, d); check("R7 0x400 writable wp=1", {24'b0, d}, 32'h56);
        wp = 1'b0;
    endtask

    task automatic t_high_bits();
        logic [7:0] d;
        single(16'hF833, 8'hE1);
        peek(12'h833, d); check("R8 upper address bits ignored", {24'b0, d}, 32'hE1);
    endtask

    task automatic t_bad_addr();
        logic ak;
        bus_start(); send_byte(8'hA2, ak); bus_stop();
        check("R1 other device not acked", {31'b0, ak}, 32'h0);
        bus_start(); send_byte(8'hA1, ak); bus_stop();
        check("R1 read form not acked", {31'b0, ak}, 32'h0);
        repeat (20) @(negedge clk);
        check("R1 ignored transactions no cycle", {31'b0, busy}, 32'h0);
    endtask

    task automatic t_abort();
        logic ak; logic [7:0] d;
        bus_start(); send_byte(8'hA0, ak); send_byte(8'h08, ak); bus_stop();
        repeat (20) @(negedge clk);
        check("R9 early stop no cycle", {31'b0, busy}, 32'h0);
        peek(12'h812, d); check("R9 array untouched", {24'b0, d}, 32'h77);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_byte_write();
        t_page_wrap();
        t_polling();
        t_protect();
        t_high_bits();
        t_bad_addr();
        t_abort();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule